// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block runs the transmit side of a bus-master DMA engine. Host software builds a linked list of four-dword descriptors in system memory, loads the address of the first one into the walker and issues a queue command. The walker fetches each descriptor through a simple memory request/response port. It checks the ownership bit and then hands the frame's buffer address and lengths to a separate frame copier. The next-descriptor pointer becomes the new current address. When the walker reaches a descriptor the host still owns, it stops and raises a queue-empty interrupt.

Transmission completes later. The MAC reports it with a one-cycle done pulse and a status byte. The walker keeps a small list of frames that have been copied but not yet reported. It writes the status into the oldest of them and clears its ownership bit, which returns that descriptor to the host. If a copy is in progress when the report arrives, the walker asks the copier to pause at the next fragment boundary. It posts the status and then lets the copy continue. A queue command may arrive at any moment. It re-arms the walk, so a frame added after the walker stopped is still sent.

Top module: `txdw_walker`

## Requirements
- R1: After reset the current descriptor address is 0, the busy (queued) flag is 0, both interrupts are 0, and no memory or copy request is active.
- R2: A queue command sets the busy flag. A fetch issues reads at the current descriptor address plus 0, 4, 8 and 12, in that order and one at a time. A request stays asserted, with a stable address, until it is accepted.
- R3: If bit 15 of dword 0 is 1, the walker raises a copy request. The request carries the buffer address from dword 1, the buffer length from dword 2 bits 15:0 and the frame length from dword 0 bits 31:16. The current descriptor address is loaded with dword 3.
- R4: If bit 15 of dword 0 is 0, only dword 0 is read. The busy flag clears, the queue-empty interrupt is set, and the current descriptor address keeps its value.
- R5: A queue command in the same cycle as a not-owned response wins. The busy flag stays 1, no queue-empty interrupt is raised, and the same address is fetched again.
- R6: A queue command clears both interrupts.
- R7: On a transmit-done pulse, the walker writes dword 0 of the oldest copied-but-unreported descriptor. The value written has the frame length in bits 31:16, zeros in bits 15:8 (which returns ownership to the host) and the status byte in bits 7:0.
- R8: A transmit-done pulse that arrives during a copy asserts the hold output. The status write is issued only after the copier reports that it has paused. The copy request stays asserted throughout, and hold is released once the write is accepted.
- R9: The chain-complete interrupt is set in two cases. One is a status write that empties the unreported list while the busy flag is 0. The other is a stop on a not-owned descriptor while that list is already empty.
- R10: A host load of the current descriptor address takes effect on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_queue | input | 1 | Queue command pulse; sets the busy flag |
| cdar_wr_en | input | 1 | Host load strobe for the current descriptor address |
| cdar_wr_data | input | AW | Value loaded by the host |
| cdar | output | AW | Current descriptor address |
| txq_busy | output | 1 | Queued flag: the walk is armed |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_write | output | 1 | 1 for a status write, 0 for a descriptor read |
| mem_req_addr | output | AW | Byte address of the request |
| mem_req_wdata | output | 32 | Status write data |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| copy_req_valid | output | 1 | Copy request to the frame copier |
| copy_buf_addr | output | 32 | Fragment buffer address |
| copy_buf_len | output | 16 | Fragment length in bytes |
| copy_frame_len | output | 16 | Frame length in bytes |
| copy_hold | output | 1 | Pause request at the next fragment boundary |
| copy_held | input | 1 | Copier is paused |
| copy_done | input | 1 | Frame fully copied (pulse) |
| tx_done | input | 1 | Transmission finished (pulse) |
| tx_status | input | 8 | Status of the finished transmission |
| irq_queue_empty | output | 1 | Walk stopped on a host-owned descriptor |
| irq_chain_done | output | 1 | Walk ended and every frame has been reported |

## Verification
Suppose the fetch offset, the next-pointer capture or the head of the unreported list goes wrong. The error shows on the memory request port at the very next request, as a read or status write at an unexpected address. The bench compares every accepted request and every copy request against an ordered list it builds from the descriptors it placed in memory. A fault in the busy flag or the interrupt latches shows within a few cycles of a stop, because the bench samples the flags right after each walk halts. A fault in the pause handshake shows up in two ways: a status write issued while the copy request is active but the copier is not paused, or a status write that never appears at all.

// File: rtl/txdw_pkg.sv
package txdw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RDREQ,
      ST_RDRSP,
      ST_COPY,
      ST_POST
   } walk_st_e;

   localparam int OWN_POS     = 15;
   localparam int DESC_DWORDS = 4;
   localparam int LEN_W       = 16;
   localparam int STAT_W      = 8;
endpackage

// File: rtl/txdw_pend_fifo.sv
module txdw_pend_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full,
   output logic         last
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("txdw_pend_fifo: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic         vld_q;
      logic [W-1:0] data_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
         end else if (push && !vld_q) begin
            vld_q <= 1'b1;
         end else if (pop) begin
            vld_q <= 1'b0;
         end
      end
      always_ff @(posedge clk) begin
         if (push && !vld_q) data_q <= push_data;
      end
      assign head  = data_q;
      assign empty = !vld_q;
      assign full  = vld_q;
      assign last  = vld_q;
   end else begin : g_ring
      localparam int PW = $clog2(DEPTH);
      localparam int CW = $clog2(DEPTH + 1);
      logic [W-1:0]  slot_q [DEPTH];
      logic [PW-1:0] wp_q, rp_q;
      logic [CW-1:0] cnt_q;
      logic          do_push, do_pop;

      assign do_push = push && (cnt_q != CW'(DEPTH));
      assign do_pop  = pop && (cnt_q != '0);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
         end else begin
            if (do_push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            case ({do_push, do_pop})
               2'b10:   cnt_q <= cnt_q + 1'b1;
               2'b01:   cnt_q <= cnt_q - 1'b1;
               default: cnt_q <= cnt_q;
            endcase
         end
      end
      always_ff @(posedge clk) begin
         if (do_push) slot_q[wp_q] <= push_data;
      end
      assign head  = slot_q[rp_q];
      assign empty = (cnt_q == '0);
      assign full  = (cnt_q == CW'(DEPTH));
      assign last  = (cnt_q == CW'(1));
   end
endmodule

// File: rtl/txdw_irq.sv
module txdw_irq #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)      q[i] <= 1'b0;
         else if (set[i]) q[i] <= 1'b1;
         else if (clr[i]) q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/txdw_seq.sv
module txdw_seq import txdw_pkg::*; #(
   parameter int AW = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_queue,
   input  logic                cdar_wr_en,
   input  logic [AW-1:0]       cdar_wr_data,
   output logic [AW-1:0]       cdar,
   output logic                txq_busy,
   output logic                mem_req_valid,
   output logic                mem_req_write,
   output logic [AW-1:0]       mem_req_addr,
   output logic [31:0]         mem_req_wdata,
   input  logic                mem_req_ready,
   input  logic                mem_rsp_valid,
   input  logic [31:0]         mem_rsp_data,
   output logic                copy_req_valid,
   output logic [31:0]         copy_buf_addr,
   output logic [LEN_W-1:0]    copy_buf_len,
   output logic [LEN_W-1:0]    copy_frame_len,
   output logic                copy_hold,
   input  logic                copy_held,
   input  logic                copy_done,
   input  logic                tx_done,
   input  logic [STAT_W-1:0]   tx_status,
   output logic                pend_push,
   output logic [AW+LEN_W-1:0] pend_push_data,
   output logic                pend_pop,
   input  logic [AW+LEN_W-1:0] pend_head,
   input  logic                pend_empty,
   input  logic                pend_full,
   input  logic                pend_last,
   output logic                set_qe,
   output logic                set_chain
);
   walk_st_e          state_q;
   logic              ret_copy_q;
   logic [1:0]        widx_q;
   logic [AW-1:0]     cur_q, cdar_q;
   logic [LEN_W-1:0]  flen_q, blen_q;
   logic [31:0]       baddr_q;
   logic              stat_pend_q, queued_q;
   logic [STAT_W-1:0] stat_q;
   logic              post_go, stop;
   logic [AW-1:0]     head_addr;
   logic [LEN_W-1:0]  head_len;

   assign head_addr = pend_head[AW-1:0];
   assign head_len  = pend_head[AW+LEN_W-1:AW];
   assign post_go   = stat_pend_q && !pend_empty;
   assign stop      = (state_q == ST_RDRSP) && mem_rsp_valid && (widx_q == 2'd0)
                      && !mem_rsp_data[OWN_POS];

   assign cdar           = cdar_q;
   assign txq_busy       = queued_q;
   assign mem_req_valid  = (state_q == ST_RDREQ) || (state_q == ST_POST);
   assign mem_req_write  = (state_q == ST_POST);
   assign mem_req_addr   = (state_q == ST_POST) ? head_addr
                                                : cur_q + AW'({widx_q, 2'b00});
   assign mem_req_wdata  = {head_len, {(16 - STAT_W){1'b0}}, stat_q};
   assign copy_req_valid = (state_q == ST_COPY) || ((state_q == ST_POST) && ret_copy_q);
   assign copy_hold      = ((state_q == ST_COPY) && post_go)
                           || ((state_q == ST_POST) && ret_copy_q);
   assign copy_buf_addr  = baddr_q;
   assign copy_buf_len   = blen_q;
   assign copy_frame_len = flen_q;
   assign pend_push      = (state_q == ST_COPY) && copy_done;
   assign pend_push_data = {flen_q, cur_q};
   assign pend_pop       = (state_q == ST_POST) && mem_req_ready;
   assign set_qe         = stop && !cmd_queue;
   assign set_chain      = (stop && !cmd_queue && pend_empty)
                           || (pend_pop && pend_last && !ret_copy_q && !queued_q && !cmd_queue);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         ret_copy_q <= 1'b0;
         widx_q     <= '0;
         cur_q      <= '0;
         cdar_q     <= '0;
         flen_q     <= '0;
         blen_q     <= '0;
         baddr_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (post_go) begin
                  state_q    <= ST_POST;
                  ret_copy_q <= 1'b0;
               end else if (queued_q && !pend_full) begin
                  state_q <= ST_RDREQ;
                  widx_q  <= '0;
                  cur_q   <= cdar_q;
               end
            end
            ST_RDREQ: if (mem_req_ready) state_q <= ST_RDRSP;
            ST_RDRSP: begin
               if (mem_rsp_valid) begin
                  case (widx_q)
                     2'd0: begin
                        if (!mem_rsp_data[OWN_POS]) begin
                           state_q <= ST_IDLE;
                        end else begin
                           flen_q  <= mem_rsp_data[31:16];
                           widx_q  <= 2'd1;
                           state_q <= ST_RDREQ;
                        end
                     end
                     2'd1: begin
                        baddr_q <= mem_rsp_data;
                        widx_q  <= 2'd2;
                        state_q <= ST_RDREQ;
                     end
                     2'd2: begin
                        blen_q  <= mem_rsp_data[LEN_W-1:0];
                        widx_q  <= 2'd3;
                        state_q <= ST_RDREQ;
                     end
                     default: begin
                        cdar_q  <= mem_rsp_data[AW-1:0];
                        state_q <= ST_COPY;
                     end
                  endcase
               end
            end
            ST_COPY: begin
               if (copy_done) begin
                  state_q <= ST_IDLE;
               end else if (post_go && copy_held) begin
                  state_q    <= ST_POST;
                  ret_copy_q <= 1'b1;
               end
            end
            ST_POST: if (mem_req_ready) state_q <= ret_copy_q ? ST_COPY : ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
         if (cdar_wr_en) cdar_q <= cdar_wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         queued_q    <= 1'b0;
         stat_pend_q <= 1'b0;
         stat_q      <= '0;
      end else begin
         if (cmd_queue)  queued_q <= 1'b1;
         else if (stop)  queued_q <= 1'b0;
         if (tx_done) begin
            stat_pend_q <= 1'b1;
            stat_q      <= tx_status;
         end else if (pend_pop) begin
            stat_pend_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/txdw_walker.sv
module txdw_walker import txdw_pkg::*; #(
   parameter int AW         = 16,
   parameter int PEND_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_queue,
   input  logic              cdar_wr_en,
   input  logic [AW-1:0]     cdar_wr_data,
   output logic [AW-1:0]     cdar,
   output logic              txq_busy,
   output logic              mem_req_valid,
   output logic              mem_req_write,
   output logic [AW-1:0]     mem_req_addr,
   output logic [31:0]       mem_req_wdata,
   input  logic              mem_req_ready,
   input  logic              mem_rsp_valid,
   input  logic [31:0]       mem_rsp_data,
   output logic              copy_req_valid,
   output logic [31:0]       copy_buf_addr,
   output logic [15:0]       copy_buf_len,
   output logic [15:0]       copy_frame_len,
   output logic              copy_hold,
   input  logic              copy_held,
   input  logic              copy_done,
   input  logic              tx_done,
   input  logic [7:0]        tx_status,
   output logic              irq_queue_empty,
   output logic              irq_chain_done
);
   localparam int PEND_W = AW + LEN_W;

   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("txdw_walker: AW must lie in 8..32");
   end
   if (PEND_DEPTH < 1) begin : g_bad_pend
      $error("txdw_walker: PEND_DEPTH must be at least 1");
   end

   logic              pend_push, pend_pop, pend_empty, pend_full, pend_last;
   logic [PEND_W-1:0] pend_push_data, pend_head;
   logic              set_qe, set_chain;
   logic [1:0]        irq_q;

   txdw_seq #(.AW(AW)) i_seq (
      .clk, .rst_n, .cmd_queue, .cdar_wr_en, .cdar_wr_data, .cdar, .txq_busy,
      .mem_req_valid, .mem_req_write, .mem_req_addr, .mem_req_wdata, .mem_req_ready,
      .mem_rsp_valid, .mem_rsp_data,
      .copy_req_valid, .copy_buf_addr, .copy_buf_len, .copy_frame_len,
      .copy_hold, .copy_held, .copy_done, .tx_done, .tx_status,
      .pend_push, .pend_push_data, .pend_pop, .pend_head, .pend_empty,
      .pend_full, .pend_last, .set_qe, .set_chain
   );

   txdw_pend_fifo #(.W(PEND_W), .DEPTH(PEND_DEPTH)) i_pend (
      .clk, .rst_n, .push(pend_push), .push_data(pend_push_data), .pop(pend_pop),
      .head(pend_head), .empty(pend_empty), .full(pend_full), .last(pend_last)
   );

   txdw_irq #(.N(2)) i_irq (
      .clk, .rst_n, .set({set_chain, set_qe}), .clr({cmd_queue, cmd_queue}), .q(irq_q)
   );

   assign irq_queue_empty = irq_q[0];
   assign irq_chain_done  = irq_q[1];
endmodule

// File: rtl/txdw_walker_chk.sv
module txdw_walker_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_queue,
   input logic          cdar_wr_en,
   input logic [AW-1:0] cdar,
   input logic          txq_busy,
   input logic          mem_req_valid,
   input logic          mem_req_write,
   input logic          mem_req_ready,
   input logic [AW-1:0] mem_req_addr,
   input logic          wb_own,
   input logic          copy_req_valid,
   input logic          copy_hold,
   input logic          copy_held,
   input logic          irq_queue_empty
);
   AST_HOLD_NEEDS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      copy_hold |-> copy_req_valid); // R8
   AST_WRITE_ONLY_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_write && copy_req_valid |-> copy_held); // R8
   AST_WB_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_write |-> !wb_own); // R7
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
                                          && $stable(mem_req_write)); // R2
   AST_QUEUE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_queue |=> txq_busy); // R5
   AST_QE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_queue |=> !irq_queue_empty); // R6
   AST_CDAR_KEPT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_queue_empty) && !$past(cdar_wr_en) |-> $stable(cdar)); // R4
   AST_STOP_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_queue_empty) |-> !txq_busy); // R4
endmodule

bind txdw_walker txdw_walker_chk #(.AW(AW)) i_chk (
   .clk(clk), .rst_n(rst_n), .cmd_queue(cmd_queue), .cdar_wr_en(cdar_wr_en),
   .cdar(cdar), .txq_busy(txq_busy), .mem_req_valid(mem_req_valid),
   .mem_req_write(mem_req_write), .mem_req_ready(mem_req_ready),
   .mem_req_addr(mem_req_addr), .wb_own(mem_req_wdata[15]),
   .copy_req_valid(copy_req_valid), .copy_hold(copy_hold), .copy_held(copy_held),
   .irq_queue_empty(irq_queue_empty)
);

// File: tb/test_txdw_walker.sv
module test_txdw_walker;
   localparam int AW       = 16;
   localparam int COPY_CYC = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_queue = 1'b0;
   logic          cdar_wr_en = 1'b0;
   logic [AW-1:0] cdar_wr_data = '0;
   logic [AW-1:0] cdar;
   logic          txq_busy;
   logic          mem_req_valid, mem_req_write;
   logic [AW-1:0] mem_req_addr;
   logic [31:0]   mem_req_wdata;
   logic          mem_req_ready = 1'b0;
   logic          mem_rsp_valid = 1'b0;
   logic [31:0]   mem_rsp_data = '0;
   logic          copy_req_valid;
   logic [31:0]   copy_buf_addr;
   logic [15:0]   copy_buf_len, copy_frame_len;
   logic          copy_hold;
   logic          copy_held = 1'b0;
   logic          copy_done = 1'b0;
   logic          tx_done = 1'b0;
   logic [7:0]    tx_status = '0;
   logic          irq_queue_empty, irq_chain_done;

   int checks = 0;
   int errors = 0;
   int paused_posts = 0;
   int rcnt = 0;
   int ccnt = 0;
   logic copy_seen = 1'b0;
   logic [31:0] hmem [0:63];
   logic [48:0] exp_mem [$];
   logic [63:0] exp_copy [$];
   logic [48:0] em;
   logic [63:0] ec;

   always #2.5 clk = ~clk;

   txdw_walker #(.AW(AW), .PEND_DEPTH(2)) i_txdw_walker (
      .clk, .rst_n, .cmd_queue, .cdar_wr_en, .cdar_wr_data, .cdar, .txq_busy,
      .mem_req_valid, .mem_req_write, .mem_req_addr, .mem_req_wdata, .mem_req_ready,
      .mem_rsp_valid, .mem_rsp_data,
      .copy_req_valid, .copy_buf_addr, .copy_buf_len, .copy_frame_len,
      .copy_hold, .copy_held, .copy_done, .tx_done, .tx_status,
      .irq_queue_empty, .irq_chain_done
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic push_rd(input logic [15:0] a);
      exp_mem.push_back({1'b0, a, 32'h0});
   endtask
   task automatic push_wr(input logic [15:0] a, input logic [31:0] d);
      exp_mem.push_back({1'b1, a, d});
   endtask

   // memory model, copier model and ready pattern
   always @(posedge clk) begin
      rcnt          <= rcnt + 1;
      mem_req_ready <= rst_n && ((rcnt % 3) != 1);
      mem_rsp_valid <= 1'b0;
      if (rst_n && mem_req_valid && mem_req_ready) begin
         if (mem_req_write) hmem[mem_req_addr[7:2]] <= mem_req_wdata;
         else begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= hmem[mem_req_addr[7:2]];
         end
      end
      copy_done <= 1'b0;
      copy_held <= copy_req_valid && copy_hold;
      if (!copy_req_valid) ccnt <= 0;
      else if (!copy_hold && !copy_done) begin
         if (ccnt == COPY_CYC - 1) begin
            copy_done <= 1'b1;
            ccnt      <= 0;
         end else ccnt <= ccnt + 1;
      end
   end

   // transaction monitor: every accepted request against the expected order
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write && copy_req_valid) paused_posts++;
            if (exp_mem.size() == 0) begin
               chk("R2 unexpected request", {mem_req_write, mem_req_addr}, 64'h0);
               if ({mem_req_write, mem_req_addr} == '0) begin
                  errors++;
                  $display("FAIL R2: extra request actual %h expected none", mem_req_addr);
               end
            end else begin
               em = exp_mem.pop_front();
               chk(mem_req_write ? "R7 status write" : "R2 descriptor read",
                   {mem_req_write, mem_req_addr, mem_req_write ? mem_req_wdata : 32'h0},
                   {15'h0, em});
            end
         end
         if (copy_req_valid && !copy_seen) begin
            copy_seen = 1'b1;
            if (exp_copy.size() == 0) begin
               errors++;
               checks++;
               $display("FAIL R3: extra copy actual %h expected none", copy_buf_addr);
            end else begin
               ec = exp_copy.pop_front();
               chk("R3 copy request", {copy_buf_addr, copy_buf_len, copy_frame_len}, ec);
            end
         end
         if (!copy_req_valid) copy_seen = 1'b0;
      end
   end

   task automatic pulse_queue();
      @(negedge clk) cmd_queue = 1'b1;
      @(negedge clk) cmd_queue = 1'b0;
   endtask
   task automatic pulse_done(input logic [7:0] st);
      @(negedge clk) begin tx_done = 1'b1; tx_status = st; end
      @(negedge clk) tx_done = 1'b0;
   endtask
   task automatic wait_stop();
      int n = 0;
      do begin @(negedge clk); n++; end while (txq_busy && n < 4000);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) hmem[i] = '0;
      // descriptor A at 0x10, B at 0x20, C at 0x30 (host owned)
      hmem[4] = 32'h003C_8000; hmem[5] = 32'h1000_0000; hmem[6] = 32'h0000_003C; hmem[7] = 32'h20;
      hmem[8] = 32'h0064_8000; hmem[9] = 32'h2000_0000; hmem[10] = 32'h0000_0064; hmem[11] = 32'h30;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 cdar", cdar, 0);
      chk("R1 busy", txq_busy, 0);
      chk("R1 queue empty irq", irq_queue_empty, 0);
      chk("R1 chain irq", irq_chain_done, 0);
      chk("R1 mem request", mem_req_valid, 0);
      chk("R1 copy request", copy_req_valid, 0);

      cdar_wr_data = 16'h0010; cdar_wr_en = 1'b1;
      @(negedge clk) cdar_wr_en = 1'b0;
      chk("R10 host load", cdar, 16'h0010);

      // walk A, B; report A while B copies; stop on C
      for (int a = 16'h10; a < 16'h20; a += 4) push_rd(16'(a));
      for (int a = 16'h20; a < 16'h30; a += 4) push_rd(16'(a));
      push_wr(16'h10, 32'h003C_00A5);
      push_rd(16'h30);
      push_wr(16'h20, 32'h0064_005B);
      exp_copy.push_back({32'h1000_0000, 16'd60, 16'd60});
      exp_copy.push_back({32'h2000_0000, 16'd100, 16'd100});
      pulse_queue();
      chk("R2 busy after queue", txq_busy, 1);
      begin
         int n = 0;
         while (!(copy_req_valid && copy_buf_addr == 32'h2000_0000) && n < 4000) begin
            @(negedge clk); n++;
         end
      end
      pulse_done(8'hA5);
      wait_stop();
      chk("R8 status posted during paused copy", paused_posts, 1);
      chk("R8 hold released", copy_hold, 0);
      chk("R4 cdar kept at host-owned descriptor", cdar, 16'h0030);
      chk("R4 queue empty irq", irq_queue_empty, 1);
      chk("R9 chain irq held while a report is pending", irq_chain_done, 0);
      chk("R7 ownership returned for A", hmem[4], 32'h003C_00A5);
      pulse_done(8'h5B);
      repeat (10) @(negedge clk);
      chk("R9 chain irq after last report", irq_chain_done, 1);
      chk("R7 ownership returned for B", hmem[8], 32'h0064_005B);

      // late addition: C made valid, D at 0x40 host owned
      hmem[12] = 32'h0028_8000; hmem[13] = 32'h3000_0000; hmem[14] = 32'h0000_0028; hmem[15] = 32'h40;
      for (int a = 16'h30; a < 16'h40; a += 4) push_rd(16'(a));
      push_rd(16'h40);
      exp_copy.push_back({32'h3000_0000, 16'd40, 16'd40});
      pulse_queue();
      chk("R6 queue empty irq cleared", irq_queue_empty, 0);
      chk("R6 chain irq cleared", irq_chain_done, 0);
      wait_stop();
      chk("R3 cdar loaded from next field", cdar, 16'h0040);
      chk("R4 queue empty irq on D", irq_queue_empty, 1);
      chk("R9 no chain irq with C unreported", irq_chain_done, 0);
      push_wr(16'h30, 32'h0028_0077);
      pulse_done(8'h77);
      repeat (10) @(negedge clk);
      chk("R9 chain irq after C reported", irq_chain_done, 1);

      // queue command coinciding with the host-owned response
      push_rd(16'h40);
      push_rd(16'h40);
      pulse_queue();
      begin
         int n = 0;
         while (!(mem_req_valid && mem_req_ready) && n < 4000) begin
            @(negedge clk); n++;
         end
      end
      @(posedge clk);
      @(negedge clk) cmd_queue = 1'b1;
      @(negedge clk) cmd_queue = 1'b0;
      chk("R5 busy kept by coinciding queue", txq_busy, 1);
      chk("R5 no queue empty irq", irq_queue_empty, 0);
      wait_stop();
      chk("R5 refetch then stop", irq_queue_empty, 1);
      chk("R9 chain irq on stop with empty list", irq_chain_done, 1);
      chk("R2 all expected requests seen", exp_mem.size(), 0);
      chk("R3 all expected copies seen", exp_copy.size(), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule